// File: doc/BRIEF.md
# Watchdog Timer with Reset Sequencer

This block guards a small microcontroller against firmware that stops running. It counts coarse ticks taken from a free-running prescaler. Any write cycle to one dedicated, write-only I/O address clears the count, whatever data the write carries. If firmware lets the count run out, the block raises a system reset request. The request lasts a fixed number of fine prescaler ticks and then drops, so the core restarts from its reset vector.

A timeout also sets a sticky status flag. Firmware reads the flag after the restart to learn why it was reset, and clears it by writing 0. The timeout also wipes a peripheral device-address register. The top bit of that register enables a transmitter, so the transmitter stays silent until firmware writes the register again with its top bit set.

Both tick rates come in as one-cycle pulses. With real prescaler taps, a long tick comes every 4.096 ms and a short tick every 2.048 ms. A bench can drive the same pulses at a much shorter, scaled rate.

Top module: `wdt_rst_seq`

## Requirements
- R1: While `por_i` is high, and after it falls, `rst_req_o`, `wdt_flag_o` and `tx_en_o` are 0, and `dev_addr_o` is 0. Power-on reset acts asynchronously.
- R2: An I/O write (`io_wr_i` high) whose address equals `CLR_ADDR` (default 0x26) clears the timeout count. A write to any other address leaves the count unchanged.
- R3: `rst_req_o` rises in the cycle after the third `tick_long_i` pulse that follows the last clear, or that follows the end of the last reset pulse. It never rises after only two such pulses.
- R4: When a long tick and a clearing write arrive in the same cycle, the clear wins, and that tick is not counted.
- R5: Once raised, `rst_req_o` stays high until the `PULSE_TICKS`-th (default 2) `tick_short_i` pulse seen while it is high. It falls in the cycle after that pulse. A short tick in the cycle that raises it is not counted.
- R6: While `rst_req_o` is high, long ticks and clearing writes have no effect on the pulse. The timeout count restarts from zero when the pulse ends.
- R7: A timeout sets `wdt_flag_o`, and the flag stays set. A write on `stat_wr_i` with `stat_wdata_i` = 0 clears it, and a write with 1 leaves it unchanged. If a timeout and a clearing write arrive in the same cycle, the flag is set.
- R8: A write on `dev_wr_i` stores `dev_wdata_i`. Bit 7 of the stored value drives `tx_en_o`, and bits 6:0 appear on `dev_addr_o`.
- R9: A timeout clears the device-address register, so `tx_en_o` and `dev_addr_o` read 0. Writes to that register are ignored while `rst_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| tick_long_i | input | 1 | Coarse prescaler tick, one cycle wide |
| tick_short_i | input | 1 | Fine prescaler tick that sets the reset length, one cycle wide |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | IO_AW (8) | I/O write address |
| stat_wr_i | input | 1 | Status flag write strobe |
| stat_wdata_i | input | 1 | Status flag write value; 0 clears the flag |
| dev_wr_i | input | 1 | Device-address register write strobe |
| dev_wdata_i | input | DEV_W (8) | Device-address register write data; the MSB is the transmitter enable |
| rst_req_o | output | 1 | System reset request |
| wdt_flag_o | output | 1 | Sticky flag: a watchdog reset has occurred |
| tx_en_o | output | 1 | Transmitter enable |
| dev_addr_o | output | DEV_W-1 (7) | Device address field |

## Verification
Each result is due exactly one clock edge after the input cycle that causes it:
- the reset request rises on the edge that samples the third uncleared long tick;
- it falls on the edge that samples the last short tick of the pulse;
- the flag and the device register follow the edge that samples their write or the timeout.

The bench drives every stimulus for one full cycle, starting at a falling edge. It samples the outputs at the next falling edge, half a cycle after the only edge that can change them. Power-on reset is checked while it is still high, to show that it acts without a clock. Sweeps cover each tick count before a clear, every non-matching I/O address, and the coincident tick/clear and timeout/flag-write cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic {
      PH_RUN   = 1'b0,
      PH_RESET = 1'b1
   } wdt_phase_e;

endpackage

// File: rtl/wdt_clr_decode.sv
module wdt_clr_decode #(
   parameter int                 IO_AW    = 8,
   parameter logic [IO_AW-1:0]   CLR_ADDR = 8'h26
) (
   input  logic              io_wr_i,
   input  logic [IO_AW-1:0]  io_addr_i,
   output logic              clr_o
);

   // full-width match: no partial decode aliases onto the clear port
   assign clr_o = io_wr_i && (io_addr_i == CLR_ADDR);

endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt #(
   parameter int CNT_W = 2,
   parameter int TERM  = 2
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic tick_i,
   input  logic clr_i,
   input  logic hold_i,
   output logic fire_o
);

   localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

   logic [CNT_W-1:0] cnt_q;
   logic             at_term;

   assign at_term = (cnt_q == TERM_V);
   // a tick at the terminal value fires instead of advancing
   assign fire_o  = tick_i && !clr_i && !hold_i && at_term;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         cnt_q <= '0;
      end else if (hold_i || clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (at_term) cnt_q <= '0;
         else         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
   import wdt_pkg::*;
#(
   parameter int PULSE_TICKS = 2
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic fire_i,
   input  logic tick_i,
   output logic active_o
);

   wdt_phase_e phase_q;

   assign active_o = (phase_q == PH_RESET);

   generate
      if (PULSE_TICKS == 1) begin : g_single
         always_ff @(posedge clk_i or posedge por_i) begin
            if (por_i) begin
               phase_q <= PH_RUN;
            end else begin
               case (phase_q)
                  PH_RUN:   if (fire_i) phase_q <= PH_RESET;
                  PH_RESET: if (tick_i) phase_q <= PH_RUN;
                  default:  phase_q <= PH_RUN;
               endcase
            end
         end
      end else begin : g_multi
         localparam int          PW   = $clog2(PULSE_TICKS);
         localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);
         logic [PW-1:0] len_q;

         always_ff @(posedge clk_i or posedge por_i) begin
            if (por_i) begin
               phase_q <= PH_RUN;
               len_q   <= '0;
            end else begin
               case (phase_q)
                  PH_RUN: begin
                     len_q <= '0;
                     if (fire_i) phase_q <= PH_RESET;
                  end
                  PH_RESET: begin
                     if (tick_i) begin
                        if (len_q == LAST) begin
                           phase_q <= PH_RUN;
                           len_q   <= '0;
                        end else begin
                           len_q <= len_q + 1'b1;
                        end
                     end
                  end
                  default: phase_q <= PH_RUN;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wdt_dev_reg.sv
module wdt_dev_reg #(
   parameter int DEV_W = 8
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             wipe_i,
   input  logic             wr_i,
   input  logic [DEV_W-1:0] wdata_i,
   output logic             tx_en_o,
   output logic [DEV_W-2:0] addr_o
);

   logic [DEV_W-1:0] reg_q;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)      reg_q <= '0;
      else if (wipe_i) reg_q <= '0;
      else if (wr_i)  reg_q <= wdata_i;
   end

   assign tx_en_o = reg_q[DEV_W-1];
   assign addr_o  = reg_q[DEV_W-2:0];

endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq #(
   parameter int               IO_AW       = 8,
   parameter logic [IO_AW-1:0] CLR_ADDR    = 8'h26,
   parameter int               CNT_W       = 2,
   parameter int               TERM        = 2,
   parameter int               PULSE_TICKS = 2,
   parameter int               DEV_W       = 8
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             tick_long_i,
   input  logic             tick_short_i,
   input  logic             io_wr_i,
   input  logic [IO_AW-1:0] io_addr_i,
   input  logic             stat_wr_i,
   input  logic             stat_wdata_i,
   input  logic             dev_wr_i,
   input  logic [DEV_W-1:0] dev_wdata_i,
   output logic             rst_req_o,
   output logic             wdt_flag_o,
   output logic             tx_en_o,
   output logic [DEV_W-2:0] dev_addr_o
);

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (TERM < 1 || TERM > CNT_MAX) begin : g_bad_term
         $error("TERM must lie in 1..2**CNT_W-1");
      end
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("PULSE_TICKS must be at least 1");
      end
      if (DEV_W < 2) begin : g_bad_dev
         $error("DEV_W must be at least 2");
      end
   endgenerate

   logic clr;
   logic fire;
   logic active;
   logic flag_q;

   wdt_clr_decode #(.IO_AW(IO_AW), .CLR_ADDR(CLR_ADDR)) u_dec (
      .io_wr_i   (io_wr_i),
      .io_addr_i (io_addr_i),
      .clr_o     (clr)
   );

   wdt_timeout_cnt #(.CNT_W(CNT_W), .TERM(TERM)) u_cnt (
      .clk_i  (clk_i),
      .por_i  (por_i),
      .tick_i (tick_long_i),
      .clr_i  (clr),
      .hold_i (active),
      .fire_o (fire)
   );

   wdt_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk_i    (clk_i),
      .por_i    (por_i),
      .fire_i   (fire),
      .tick_i   (tick_short_i),
      .active_o (active)
   );

   wdt_dev_reg #(.DEV_W(DEV_W)) u_dev (
      .clk_i   (clk_i),
      .por_i   (por_i),
      .wipe_i  (fire || active),
      .wr_i    (dev_wr_i),
      .wdata_i (dev_wdata_i),
      .tx_en_o (tx_en_o),
      .addr_o  (dev_addr_o)
   );

   // sticky cause flag: set beats firmware clear
   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)                           flag_q <= 1'b0;
      else if (fire)                       flag_q <= 1'b1;
      else if (stat_wr_i && !stat_wdata_i) flag_q <= 1'b0;
   end

   assign rst_req_o  = active;
   assign wdt_flag_o = flag_q;

endmodule

// File: rtl/wdt_rst_seq_chk.sv
module wdt_rst_seq_chk #(
   parameter int               IO_AW    = 8,
   parameter logic [IO_AW-1:0] CLR_ADDR = 8'h26
) (
   input logic             clk_i,
   input logic             por_i,
   input logic             tick_long_i,
   input logic             tick_short_i,
   input logic             io_wr_i,
   input logic [IO_AW-1:0] io_addr_i,
   input logic             stat_wr_i,
   input logic             stat_wdata_i,
   input logic             rst_req_o,
   input logic             wdt_flag_o,
   input logic             tx_en_o
);

   AST_RISE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(rst_req_o) |-> $past(tick_long_i)) else $error("rise without long tick"); // R3

   AST_CLEAR_BLOCKS_FIRE: assert property (@(posedge clk_i) disable iff (por_i)
      (io_wr_i && io_addr_i == CLR_ADDR && !rst_req_o) |=> !rst_req_o) else $error("fired on clear"); // R4

   AST_FALL_NEEDS_SHORT: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(rst_req_o) |-> $past(tick_short_i)) else $error("fall without short tick"); // R5

   AST_FLAG_WITH_RESET: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(rst_req_o) |-> wdt_flag_o) else $error("flag missing"); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (por_i)
      (wdt_flag_o && !(stat_wr_i && !stat_wdata_i)) |=> wdt_flag_o) else $error("flag lost"); // R7

   AST_TX_OFF_IN_RESET: assert property (@(posedge clk_i) disable iff (por_i)
      rst_req_o |-> !tx_en_o) else $error("tx on in reset"); // R9

endmodule

bind wdt_rst_seq wdt_rst_seq_chk #(.IO_AW(IO_AW), .CLR_ADDR(CLR_ADDR)) u_chk (
   .clk_i        (clk_i),
   .por_i        (por_i),
   .tick_long_i  (tick_long_i),
   .tick_short_i (tick_short_i),
   .io_wr_i      (io_wr_i),
   .io_addr_i    (io_addr_i),
   .stat_wr_i    (stat_wr_i),
   .stat_wdata_i (stat_wdata_i),
   .rst_req_o    (rst_req_o),
   .wdt_flag_o   (wdt_flag_o),
   .tx_en_o      (tx_en_o)
);

// File: tb/wdt_rst_seq_tb.sv
module wdt_rst_seq_tb;

   localparam logic [7:0] CLR_A = 8'h26;

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       tl = 1'b0, ts = 1'b0, iw = 1'b0, sw = 1'b0, sv = 1'b0, dw = 1'b0;
   logic [7:0] ia = 8'h00, dv = 8'h00;
   logic       rst_req, flag, tx_en;
   logic [6:0] dev_addr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wdt_rst_seq u_dut (
      .clk_i        (clk),
      .por_i        (por),
      .tick_long_i  (tl),
      .tick_short_i (ts),
      .io_wr_i      (iw),
      .io_addr_i    (ia),
      .stat_wr_i    (sw),
      .stat_wdata_i (sv),
      .dev_wr_i     (dw),
      .dev_wdata_i  (dv),
      .rst_req_o    (rst_req),
      .wdt_flag_o   (flag),
      .tx_en_o      (tx_en),
      .dev_addr_o   (dev_addr)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one cycle of stimulus, launched at a falling edge; returns at the next falling edge
   task automatic cyc(input logic a_tl, input logic a_ts, input logic a_iw, input logic [7:0] a_ia,
                      input logic a_sw, input logic a_sv, input logic a_dw, input logic [7:0] a_dv);
      tl = a_tl; ts = a_ts; iw = a_iw; ia = a_ia; sw = a_sw; sv = a_sv; dw = a_dw; dv = a_dv;
      @(negedge clk);
      tl = 0; ts = 0; iw = 0; ia = 0; sw = 0; sv = 0; dw = 0; dv = 0;
   endtask

   task automatic long_tick();  cyc(1, 0, 0, 8'h00, 0, 0, 0, 8'h00); endtask
   task automatic short_tick(); cyc(0, 1, 0, 8'h00, 0, 0, 0, 8'h00); endtask
   task automatic io_write(input logic [7:0] a); cyc(0, 0, 1, a, 0, 0, 0, 8'h00); endtask
   task automatic dev_write(input logic [7:0] d); cyc(0, 0, 0, 8'h00, 0, 0, 1, d); endtask
   task automatic stat_write(input logic v); cyc(0, 0, 0, 8'h00, 1, v, 0, 8'h00); endtask

   task automatic release_pulse();
      short_tick();
      check("R5 still high after first short tick", rst_req, 1);
      short_tick();
      check("R5 low after second short tick", rst_req, 0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      #1;
      check("R1 rst_req in por", rst_req, 0);
      check("R1 flag in por", flag, 0);
      check("R1 tx_en in por", tx_en, 0);
      por = 1'b0;
      @(negedge clk);
      check("R1 rst_req after por", rst_req, 0);
      check("R1 dev_addr after por", dev_addr, 0);

      // R2/R3: n ticks then clear, then two ticks safe, third fires
      for (int n = 0; n < 3; n++) begin
         for (int k = 0; k < n; k++) long_tick();
         check("R3 no reset before timeout", rst_req, 0);
         io_write(CLR_A);
         long_tick();
         long_tick();
         check("R2 cleared: no reset after two ticks", rst_req, 0);
         long_tick();
         check("R3 reset after third tick", rst_req, 1);
         check("R7 flag set by timeout", flag, 1);
         release_pulse();
      end

      // R2: writes to every other address do not clear
      for (int a = 0; a < 256; a++) begin
         if (a != int'(CLR_A)) begin
            long_tick();
            long_tick();
            io_write(8'(a));
            long_tick();
            check("R2 wrong address does not clear", rst_req, 1);
            short_tick();
            short_tick();
         end
      end

      // R4: tick and clear in the same cycle
      long_tick();
      long_tick();
      cyc(1, 0, 1, CLR_A, 0, 0, 0, 8'h00);
      check("R4 coincident clear wins", rst_req, 0);
      long_tick();
      long_tick();
      check("R4 count restarted at zero", rst_req, 0);
      long_tick();
      check("R4 fires after three fresh ticks", rst_req, 1);

      // R6: long ticks and clears ignored during the pulse
      for (int k = 0; k < 4; k++) long_tick();
      io_write(CLR_A);
      check("R6 pulse held through ticks and clear", rst_req, 1);
      // R9: device write ignored while pulse is high
      dev_write(8'h85);
      check("R9 tx_en stays off in reset", tx_en, 0);
      check("R9 dev_addr stays zero in reset", dev_addr, 0);
      release_pulse();
      long_tick();
      long_tick();
      check("R6 count starts from zero after release", rst_req, 0);
      long_tick();
      check("R6 fires on third tick after release", rst_req, 1);

      // R5: short tick in the raising cycle is not counted
      short_tick();
      short_tick();
      check("R5 released", rst_req, 0);
      long_tick();
      long_tick();
      cyc(1, 1, 0, 8'h00, 0, 0, 0, 8'h00);
      check("R5 raised with coincident short tick", rst_req, 1);
      release_pulse();

      // R7: flag behaviour
      stat_write(1'b1);
      check("R7 write of 1 keeps flag", flag, 1);
      stat_write(1'b0);
      check("R7 write of 0 clears flag", flag, 0);
      long_tick();
      long_tick();
      cyc(1, 0, 0, 8'h00, 1, 0, 0, 8'h00);
      check("R7 timeout beats clearing write", flag, 1);
      release_pulse();
      stat_write(1'b0);
      io_write(CLR_A);

      // R8: register storage and enable bit
      dev_write(8'h85);
      check("R8 tx_en from bit 7", tx_en, 1);
      check("R8 dev_addr from bits 6:0", dev_addr, 5);
      dev_write(8'h3A);
      check("R8 tx_en off when bit 7 is 0", tx_en, 0);
      check("R8 dev_addr updated", dev_addr, 8'h3A);
      dev_write(8'hFF);
      check("R8 tx_en on", tx_en, 1);

      // R9: timeout wipes the register
      io_write(CLR_A);
      long_tick();
      long_tick();
      long_tick();
      check("R9 tx_en cleared by timeout", tx_en, 0);
      check("R9 dev_addr cleared by timeout", dev_addr, 0);
      release_pulse();
      check("R9 tx_en still off after release", tx_en, 0);
      dev_write(8'h81);
      check("R9 re-enabled by firmware write", tx_en, 1);

      // R1: asynchronous power-on reset mid-pulse
      long_tick();
      long_tick();
      long_tick();
      check("R1 pulse active before por", rst_req, 1);
      #2;
      por = 1'b1;
      #1;
      check("R1 por drops rst_req", rst_req, 0);
      check("R1 por clears flag", flag, 0);
      check("R1 por clears tx_en", tx_en, 0);
      @(negedge clk);
      por = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule